// File: doc/BRIEF.md
# Extended Register Operand Generator

The block builds the second ALU operand for arithmetic that takes an extended register. It receives the value read from a general register, the index of that register, a 3-bit extend option, a 3-bit left-shift amount and a flag that chooses 32-bit or 64-bit operation. From these it takes a low field of the register, zero-extends or sign-extends it, and shifts it left by up to four places. The result is an operand of the chosen width. Register index 31 is treated as a hard zero on this path.

The shift and the extension are done in a single step. The field length is clipped to the operating width minus the shift, and the shift zeros are appended below the field. The sign then comes from the top bit of the shifted field. The result matches extending first and shifting second, truncated to the operating width, and a shifted field never runs past the top of the operand. A shift amount above four is flagged and gives a zero operand.

An output register is included by default, so the result and its valid flag appear one clock after the inputs. The register can be turned off by a parameter, which makes the path purely combinational.

Top module: `ext_operand_gen`

## Requirements
- R1: The option code selects the field length from its low two bits: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Bit 2 clear selects zero-extension, so no bit above the shifted field is set.
- R2: With option bit 2 set, the shifted field is sign-extended. Every bit above the field copies the field's top bit.
- R3: A shift amount from 0 to 4 moves the field left by that many places and fills the vacated low bits with zeros.
- R4: The effective field length is the smaller of the decoded length and the operating width minus the shift. The sign is taken from bit (effective length + shift − 1). The result equals extend-then-shift, truncated to the operating width.
- R5: When wide_i is 0 (32-bit mode), only reg_val_i[31:0] takes part and operand_o[63:32] is zero. When wide_i is 1, all 64 bits are used.
- R6: Register index 31 supplies an all-zero source value, whatever reg_val_i holds.
- R7: A shift amount of 5, 6 or 7 sets illegal_shift_o and forces operand_o to zero. For shift amounts 0 to 4, illegal_shift_o is 0.
- R8: With the output register present (REG_OUT=1), operand_o, illegal_shift_o and valid_o reflect the inputs sampled at the previous rising clock edge.
- R9: While rst_ni is low, valid_o, illegal_shift_o and operand_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input qualifier |
| reg_idx_i | input | 5 | Source register index; 31 reads as zero |
| reg_val_i | input | 64 | Value read from the register file |
| opt_i | input | 3 | Extend option: bit 2 selects signed, bits 1:0 select the length |
| shamt_i | input | 3 | Left shift amount, legal from 0 to 4 |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| valid_o | output | 1 | valid_i delayed by the output stage |
| operand_o | output | 64 | Extended and shifted operand; upper half is zero in 32-bit mode |
| illegal_shift_o | output | 1 | Set when shamt_i is above 4 |

## Verification
Each fault shows at the ports one cycle after the inputs that expose it, because the only state is the output register. A wrong length decode or a wrong clip bound shows as wrong bits just above the shifted field. A sign tap taken from the wrong position shows only when the field's top bit differs from the bit beside it, so the sweeps over every option, shift and width combination use random values and also values with a single isolated bit. A stage register that fails to update shows as the previous operand or a lagging valid in the next sample.

// File: rtl/ext_operand_pkg.sv
package ext_operand_pkg;

  localparam int unsigned LEN_W = 7;  // holds lengths 0..64

  typedef enum logic [2:0] {
    EXT_U8  = 3'b000,
    EXT_U16 = 3'b001,
    EXT_U32 = 3'b010,
    EXT_U64 = 3'b011,
    EXT_S8  = 3'b100,
    EXT_S16 = 3'b101,
    EXT_S32 = 3'b110,
    EXT_S64 = 3'b111
  } ext_opt_e;

  typedef struct packed {
    logic             is_signed;
    logic [LEN_W-1:0] len;
  } ext_dec_t;

endpackage

// File: rtl/ext_opt_decode.sv
module ext_opt_decode
  import ext_operand_pkg::*;
(
  input  logic [2:0] opt_i,
  output ext_dec_t   dec_o
);

  ext_opt_e opt;
  assign opt = ext_opt_e'(opt_i);

  always_comb begin
    dec_o = '0;
    unique case (opt)
      EXT_U8:  begin dec_o.is_signed = 1'b0; dec_o.len = LEN_W'(8);  end
      EXT_U16: begin dec_o.is_signed = 1'b0; dec_o.len = LEN_W'(16); end
      EXT_U32: begin dec_o.is_signed = 1'b0; dec_o.len = LEN_W'(32); end
      EXT_U64: begin dec_o.is_signed = 1'b0; dec_o.len = LEN_W'(64); end
      EXT_S8:  begin dec_o.is_signed = 1'b1; dec_o.len = LEN_W'(8);  end
      EXT_S16: begin dec_o.is_signed = 1'b1; dec_o.len = LEN_W'(16); end
      EXT_S32: begin dec_o.is_signed = 1'b1; dec_o.len = LEN_W'(32); end
      default: begin dec_o.is_signed = 1'b1; dec_o.len = LEN_W'(64); end
    endcase
  end

endmodule

// File: rtl/ext_field_clip.sv
module ext_field_clip
  import ext_operand_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SH_W = 3
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             wide_i,
  output logic [XLEN-1:0]  mask_o,
  output logic [LEN_W-1:0] top_o
);

  localparam logic [LEN_W-1:0] FULL_W = LEN_W'(XLEN);
  localparam logic [LEN_W-1:0] HALF_W = LEN_W'(XLEN / 2);

  logic [LEN_W-1:0] width, room, eff_len;

  always_comb begin
    width   = wide_i ? FULL_W : HALF_W;
    room    = width - LEN_W'(sh_i);
    eff_len = (len_i < room) ? len_i : room;
    // index of the sign bit after the shift
    top_o   = eff_len + LEN_W'(sh_i) - LEN_W'(1);
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_mask
    assign mask_o[b] = (LEN_W'(b) < eff_len);
  end

endmodule

// File: rtl/ext_shift_extend.sv
module ext_shift_extend
  import ext_operand_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SH_W = 3
) (
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  mask_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic [LEN_W-1:0] top_i,
  input  logic             is_signed_i,
  input  logic             wide_i,
  output logic [XLEN-1:0]  res_o
);

  localparam int unsigned PW   = $clog2(XLEN);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] shifted, ext;
  logic            sign;

  assign shifted = (src_i & mask_i) << sh_i;
  assign sign    = is_signed_i & shifted[top_i[PW-1:0]];

  for (genvar b = 0; b < XLEN; b++) begin : g_ext
    assign ext[b] = (LEN_W'(b) > top_i) ? sign : shifted[b];
  end

  assign res_o = wide_i ? ext : {{HALF{1'b0}}, ext[HALF-1:0]};

endmodule

// File: rtl/ext_out_stage.sv
module ext_out_stage #(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            flag_i,
  output logic            valid_o,
  output logic [XLEN-1:0] data_o,
  output logic            flag_o
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
        flag_o  <= 1'b0;
      end else begin
        valid_o <= valid_i;
        data_o  <= data_i;
        flag_o  <= flag_i;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
    assign flag_o  = flag_i;
  end

endmodule

// File: rtl/ext_operand_gen.sv
module ext_operand_gen
  import ext_operand_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned SH_W     = 3,
  parameter int unsigned MAX_SH   = 4,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [XLEN-1:0]  reg_val_i,
  input  logic [2:0]       opt_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             wide_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  operand_o,
  output logic             illegal_shift_o
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  ext_dec_t         dec;
  logic [XLEN-1:0]  src, mask, ext_res, result;
  logic [LEN_W-1:0] top;
  logic             bad_sh;

  assign src    = (reg_idx_i == ZERO_IDX) ? '0 : reg_val_i;
  assign bad_sh = (shamt_i > SH_W'(MAX_SH));

  ext_opt_decode u_dec (
    .opt_i (opt_i),
    .dec_o (dec)
  );

  ext_field_clip #(.XLEN(XLEN), .SH_W(SH_W)) u_clip (
    .len_i  (dec.len),
    .sh_i   (shamt_i),
    .wide_i (wide_i),
    .mask_o (mask),
    .top_o  (top)
  );

  ext_shift_extend #(.XLEN(XLEN), .SH_W(SH_W)) u_ext (
    .src_i       (src),
    .mask_i      (mask),
    .sh_i        (shamt_i),
    .top_i       (top),
    .is_signed_i (dec.is_signed),
    .wide_i      (wide_i),
    .res_o       (ext_res)
  );

  assign result = bad_sh ? '0 : ext_res;

  ext_out_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (result),
    .flag_i  (bad_sh),
    .valid_o (valid_o),
    .data_o  (operand_o),
    .flag_o  (illegal_shift_o)
  );

endmodule

// File: rtl/ext_operand_chk.sv
module ext_operand_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned SH_W    = 3,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IDX_W-1:0] reg_idx_i,
  input logic [2:0]       opt_i,
  input logic [SH_W-1:0]  shamt_i,
  input logic             wide_i,
  input logic             valid_o,
  input logic [XLEN-1:0]  operand_o,
  input logic             illegal_shift_o
);

  localparam int unsigned HALF = XLEN / 2;

  // R7: zero operand whenever the flag is up
  a_r7_flag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_shift_o |-> (operand_o == '0));

  if (REG_OUT) begin : g_seq
    // R8
    a_r8_valid_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (valid_o == $past(valid_i)));
    // R7
    a_r7_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (illegal_shift_o == ($past(shamt_i) > SH_W'(4))));
    // R5
    a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(wide_i)) |-> (operand_o[XLEN-1:HALF] == '0));
    // R6
    a_r6_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && ($past(reg_idx_i) == '1)) |-> (operand_o == '0));
    // R1: unsigned byte field cannot reach bit 12
    a_r1_byte_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && ($past(opt_i) == 3'b000)) |-> (operand_o[XLEN-1:12] == '0));
  end else begin : g_comb
    a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wide_i |-> (operand_o[XLEN-1:HALF] == '0));
    a_r6_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_idx_i == '1) |-> (operand_o == '0));
    a_r8_valid_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
    a_r1_byte_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opt_i == 3'b000) |-> (operand_o[XLEN-1:12] == '0));
  end

endmodule

bind ext_operand_gen ext_operand_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .SH_W(SH_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .valid_i         (valid_i),
  .reg_idx_i       (reg_idx_i),
  .opt_i           (opt_i),
  .shamt_i         (shamt_i),
  .wide_i          (wide_i),
  .valid_o         (valid_o),
  .operand_o       (operand_o),
  .illegal_shift_o (illegal_shift_o)
);

// File: tb/ext_operand_gen_tb.sv
module ext_operand_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  idx = 5'd1;
  logic [63:0] val = '0;
  logic [2:0]  opt = '0;
  logic [2:0]  sh = '0;
  logic        wide = 1'b1;
  logic        valid_o, ill_o;
  logic [63:0] op_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ext_operand_gen u_dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i),
    .reg_idx_i (idx), .reg_val_i (val), .opt_i (opt),
    .shamt_i (sh), .wide_i (wide), .valid_o (valid_o),
    .operand_o (op_o), .illegal_shift_o (ill_o)
  );

  // extend first, shift second, then truncate
  function automatic logic [63:0] model(logic [4:0] i, logic [63:0] v,
                                        logic [2:0] o, logic [2:0] s, logic w);
    logic [63:0] x, lowmask, f, r;
    int len;
    x = (i == 5'd31) ? 64'd0 : v;
    if (!w) x[63:32] = '0;
    len = 8 << o[1:0];
    lowmask = (len == 64) ? '1 : ((64'd1 << len) - 64'd1);
    f = x & lowmask;
    if (o[2] && len < 64 && f[len-1]) f = f | ~lowmask;
    r = f << s;
    if (!w) r[63:32] = '0;
    if (s > 3'd4) r = '0;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (opt=%0d sh=%0d wide=%0d idx=%0d val=%h)",
               req, act, exp, opt, sh, wide, idx, val);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic apply(logic [4:0] i, logic [63:0] v, logic [2:0] o,
                       logic [2:0] s, logic w);
    idx = i; val = v; opt = o; sh = s; wide = w; valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 valid", {63'd0, valid_o}, 64'd0);
    check("R9 operand", op_o, 64'd0);
    check("R9 flag", {63'd0, ill_o}, 64'd0);
  endtask

  task automatic t_unsigned();  // R1 R3
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 5; s++)
        for (int k = 0; k < 4; k++) begin
          logic [63:0] v;
          v = {$urandom, $urandom};
          if (k == 0) v = '1;
          apply(5'd3, v, 3'(o), 3'(s), 1'b1);
          check("R1/R3 unsigned", op_o, model(5'd3, v, 3'(o), 3'(s), 1'b1));
        end
  endtask

  task automatic t_signed();  // R2 R4
    for (int o = 4; o < 8; o++)
      for (int s = 0; s < 5; s++)
        for (int k = 0; k < 6; k++) begin
          logic [63:0] v;
          int len;
          len = 8 << (o % 4);
          v = {$urandom, $urandom};
          if (k == 0) v = 64'd1 << (len - 1);           // lone sign bit
          if (k == 1) v = ~(64'd1 << (len - 1));        // sign clear, rest set
          if (k == 2 && len > 1) v = 64'd1 << (len - 2); // bit below sign
          apply(5'd7, v, 3'(o), 3'(s), 1'b1);
          check("R2/R4 signed", op_o, model(5'd7, v, 3'(o), 3'(s), 1'b1));
        end
  endtask

  task automatic t_narrow();  // R5 R4
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 5; s++)
        for (int k = 0; k < 3; k++) begin
          logic [63:0] v;
          v = {$urandom, $urandom};
          if (k == 0) v = 64'hFFFF_FFFF_8000_0000;
          apply(5'd9, v, 3'(o), 3'(s), 1'b0);
          check("R5 narrow", op_o, model(5'd9, v, 3'(o), 3'(s), 1'b0));
        end
  endtask

  task automatic t_zero_reg();  // R6
    for (int o = 0; o < 8; o++) begin
      apply(5'd31, '1, 3'(o), 3'd2, 1'b1);
      check("R6 index31", op_o, 64'd0);
    end
    apply(5'd30, '1, 3'd7, 3'd0, 1'b1);
    check("R6 index30", op_o, '1);
  endtask

  task automatic t_illegal();  // R7
    for (int s = 5; s < 8; s++) begin
      apply(5'd2, '1, 3'd3, 3'(s), 1'b1);
      check("R7 flag", {63'd0, ill_o}, 64'd1);
      check("R7 zero", op_o, 64'd0);
    end
    apply(5'd2, '1, 3'd3, 3'd4, 1'b1);
    check("R7 legal4", {63'd0, ill_o}, 64'd0);
  endtask

  task automatic t_latency();  // R8
    valid_i = 1'b0; idx = 5'd4; val = 64'h55; opt = 3'd0; sh = 3'd0; wide = 1'b1;
    @(negedge clk);
    valid_i = 1'b1; val = 64'hAA;
    #1;
    check("R8 valid lag", {63'd0, valid_o}, 64'd0);
    check("R8 data lag", op_o, 64'h55);
    @(negedge clk);
    check("R8 valid", {63'd0, valid_o}, 64'd1);
    check("R8 data", op_o, 64'hAA);
    valid_i = 1'b0;
    @(negedge clk);
    check("R8 valid drop", {63'd0, valid_o}, 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned();
    t_signed();
    t_narrow();
    t_zero_reg();
    t_illegal();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule